// File: doc/BRIEF.md
# Two-Frame Elastic Store with Controlled Frame Slip

This block buffers a 2.048 Mbit/s framed bit stream between the line clock that delivers it and a backplane clock that has no fixed relation to it. The store holds two complete 256-bit frames (512 bits in all). The writer begins placing bits at the first bit that carries the frame marker. The reader plays the stored frames out on its own clock. Reads may come at the backplane's base rate or in bursts of one read per clock cycle. Only the write pointer crosses between the two clock domains, in Gray code, through a chain of synchronizing flops.

The store never lets the pointers run into each other in the middle of a frame. The reader decides what to do only when it reaches the end of a frame. If the writer is too close behind the next frame, the reader plays the frame it has just finished once more. If the writer is too close to lapping the reader, the reader skips one whole frame. Each such slip sets its own sticky flag in the read domain, and software clears each flag by writing a one to it. In the 24-channel read mode, every output frame is 193 bits long. The first bit of that frame is an inserted framing bit, and 24 of the 32 stored timeslots follow it.

Each direction of a framer uses its own instance, and the two instances share nothing.

Top module: `frame_elastic_store`

## Requirements
- R1: After reset, rd_bit is 1 and slip_flags is 00.
- R2: Write strobes that come before the first strobe with wr_fsync=1 are discarded. The marked bit becomes bit 0 of stored frame 0. Any later wr_fsync is ignored.
- R3: rd_bit stays 1 until one full frame has been written. After that, the first frame read out is frame 0, starting at its bit 0.
- R4: In E1 mode (rd_t1=0), every output frame has 256 bits, in stored order. Each read returns its bit on rd_bit in the cycle after rd_en is sampled.
- R5: When the average read and write rates are equal, no slip occurs and frames come out in sequence. This also holds with read bursts of one read per cycle.
- R6: At a frame end, the reader measures how many bits the writer has stored past the start of the next frame. If that count is below 64, the reader replays the frame it has just read, and slip_flags[0] (repeat) is set.
- R7: If the same count is above 448, the reader skips the next stored frame, and slip_flags[1] (delete) is set.
- R8: Slips happen only at frame boundaries. Every output frame is one complete stored frame. Consecutive output frames are numbered n+1 when no slip occurs, n on a repeat and n+2 on a delete.
- R9: The slip flags are sticky. Writing 1 to slip_clr[i] clears only slip_flags[i].
- R10: In T1 mode (rd_t1=1), every output frame has 193 bits. Bit 0 is the value of rd_fbit. Output bit p≥1 takes bit (p-1)%8 of stored timeslot k+k/3+1, with k=(p-1)/8. This skips every timeslot whose number is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side write clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | Data bit to store |
| wr_fsync | input | 1 | Marks the first bit of frame 0 |
| rclk | input | 1 | Backplane read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read strobe |
| rd_t1 | input | 1 | 1 selects the 193-bit output frame |
| rd_fbit | input | 1 | Framing bit value for T1 mode |
| rd_bit | output | 1 | Data bit read out |
| slip_clr | input | 2 | Write-one clear for the slip flags |
| slip_flags | output | 2 | Sticky flags: [0] repeat, [1] delete |

## Verification
Some properties are checked on every cycle by the assertions:
- the write-side Gray pointer changes by at most one bit at a time;
- the write pointer holds when there is no write strobe;
- the reader's frame base moves only at a frame end, and stays put on a repeat;
- a slip flag rises only as a new frame starts;
- the T1 frame position stays within 193 bits;
- the output stays at the idle 1 until the reader starts.

Other behaviour can only be shown by the bench's scenarios, because the bench decodes the whole output stream into frames. These are the discarded pre-marker bits, the frame contents and the timeslot map, and replay versus skip under a real rate mismatch. The sequence numbering across slips and the per-bit flag clearing are also shown this way.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int SLIP_REP = 0;
  localparam int SLIP_DEL = 1;

  // Stored timeslot read at kept-slot index k in the 24-channel map.
  // Every timeslot whose number is a multiple of four is skipped.
  function automatic int t1_slot(input int k);
    return k + k / 3 + 1;
  endfunction
endpackage

// File: rtl/es_wr.sv
module es_wr #(
  parameter int AW = 9,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          wr_fsync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          wdata,
  output logic [PW-1:0] wgray
);
  logic          started;
  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_n;

  always_comb begin
    we     = wr_en && (started || wr_fsync);
    waddr  = wptr[AW-1:0];
    wdata  = wr_bit;
    wptr_n = wptr + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      wptr    <= '0;
      wgray   <= '0;
    end else if (we) begin
      started <= 1'b1;
      wptr    <= wptr_n;
      wgray   <= wptr_n ^ (wptr_n >> 1);
    end
  end

  // R5
  wgray_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wptr));
endmodule

// File: rtl/es_sync.sv
module es_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_gray,
  output logic [W-1:0] q_bin
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_gray;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_g2b
    assign q_bin[b] = ^stg[STAGES-1][W-1:b];
  end
endmodule

// File: rtl/es_mem.sv
module es_mem #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          q
);
  logic mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/es_rd.sv
module es_rd
  import es_pkg::*;
#(
  parameter int TS_BITS = 8,
  parameter int NUM_TS  = 32,
  parameter int FRAMES  = 2
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         rd_en,
  input  logic                                         rd_t1,
  input  logic                                         rd_fbit,
  input  logic [1:0]                                   slip_clr,
  input  logic [$clog2(TS_BITS*NUM_TS*FRAMES):0]       wbin,
  output logic                                         re,
  output logic [$clog2(TS_BITS*NUM_TS*FRAMES)-1:0]     raddr,
  output logic                                         use_mem,
  output logic                                         alt_bit,
  output logic [1:0]                                   slip_flags
);
  localparam int FRAME_BITS = TS_BITS * NUM_TS;
  localparam int DEPTH      = FRAME_BITS * FRAMES;
  localparam int AW         = $clog2(DEPTH);
  localparam int PW         = AW + 1;
  localparam int OW         = $clog2(FRAME_BITS);
  localparam int T1_BITS    = (NUM_TS * 3 / 4) * TS_BITS + 1;
  localparam int MARGIN     = FRAME_BITS / 4;
  localparam logic [OW-1:0] TSB = OW'(TS_BITS);

  logic          running;
  logic [PW-1:0] rbase;
  logic [OW-1:0] pos;

  logic [OW-1:0] pm1, kk, bb, tsn, off, last;
  logic [PW-1:0] rsum, nb, fill;
  logic          is_fb, step, boundary, under, over, set_rep, set_del;

  always_comb begin
    pm1      = pos - OW'(1);
    kk       = pm1 / TSB;
    bb       = pm1 % TSB;
    tsn      = OW'(t1_slot(int'(kk)));
    off      = rd_t1 ? (tsn * TSB + bb) : pos;
    last     = rd_t1 ? OW'(T1_BITS - 1) : OW'(FRAME_BITS - 1);
    is_fb    = rd_t1 && (pos == '0);
    step     = running && rd_en;
    boundary = step && (pos == last);
    rsum     = rbase + PW'(off);
    raddr    = rsum[AW-1:0];
    re       = step && !is_fb;
    nb       = rbase + PW'(FRAME_BITS);
    fill     = wbin - nb;
    under    = $signed(fill) < $signed(PW'(MARGIN));
    over     = $signed(fill) > $signed(PW'(DEPTH - MARGIN));
    set_rep  = boundary && under;
    set_del  = boundary && !under && over;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      rbase      <= '0;
      pos        <= '0;
      use_mem    <= 1'b0;
      alt_bit    <= 1'b1;
      slip_flags <= '0;
    end else begin
      if (!running && (wbin >= PW'(FRAME_BITS))) running <= 1'b1;
      if (step) begin
        use_mem <= !is_fb;
        alt_bit <= rd_fbit;
        pos     <= boundary ? '0 : pos + OW'(1);
      end
      if (boundary) begin
        if (under)     rbase <= rbase;
        else if (over) rbase <= nb + PW'(FRAME_BITS);
        else           rbase <= nb;
      end
      slip_flags[SLIP_REP] <= (slip_flags[SLIP_REP] && !slip_clr[SLIP_REP]) || set_rep;
      slip_flags[SLIP_DEL] <= (slip_flags[SLIP_DEL] && !slip_clr[SLIP_DEL]) || set_del;
    end
  end

  // R8
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(rbase));

  // R6
  rep_replay_chk: assert property (@(posedge clk) disable iff (rst)
    set_rep |=> (rbase == $past(rbase)));

  // R8
  rep_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slip_flags[SLIP_REP]) |-> (pos == '0));

  // R8
  del_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slip_flags[SLIP_DEL]) |-> (pos == '0));

  // R10
  t1_pos_chk: assert property (@(posedge clk) disable iff (rst)
    rd_t1 |-> (pos < OW'(T1_BITS)));

  // R3
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!use_mem && alt_bit));
endmodule

// File: rtl/frame_elastic_store.sv
module frame_elastic_store #(
  parameter int TS_BITS     = 8,
  parameter int NUM_TS      = 32,
  parameter int FRAMES      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       wclk,
  input  logic       wrst,
  input  logic       wr_en,
  input  logic       wr_bit,
  input  logic       wr_fsync,
  input  logic       rclk,
  input  logic       rrst,
  input  logic       rd_en,
  input  logic       rd_t1,
  input  logic       rd_fbit,
  output logic       rd_bit,
  input  logic [1:0] slip_clr,
  output logic [1:0] slip_flags
);
  localparam int FRAME_BITS = TS_BITS * NUM_TS;
  localparam int DEPTH      = FRAME_BITS * FRAMES;
  localparam int AW         = $clog2(DEPTH);
  localparam int PW         = AW + 1;

  logic          we, wdata, re, q, use_mem, alt_bit;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, wbin;

  es_wr #(.AW(AW), .PW(PW)) u_wr (
    .clk(wclk), .rst(wrst), .wr_en(wr_en), .wr_bit(wr_bit),
    .wr_fsync(wr_fsync), .we(we), .waddr(waddr), .wdata(wdata),
    .wgray(wgray)
  );

  es_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(rclk), .rst(rrst), .d_gray(wgray), .q_bin(wbin)
  );

  es_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .re(re), .raddr(raddr), .q(q)
  );

  es_rd #(.TS_BITS(TS_BITS), .NUM_TS(NUM_TS), .FRAMES(FRAMES)) u_rd (
    .clk(rclk), .rst(rrst), .rd_en(rd_en), .rd_t1(rd_t1),
    .rd_fbit(rd_fbit), .slip_clr(slip_clr), .wbin(wbin), .re(re),
    .raddr(raddr), .use_mem(use_mem), .alt_bit(alt_bit),
    .slip_flags(slip_flags)
  );

  assign rd_bit = use_mem ? q : alt_bit;
endmodule

// File: tb/frame_elastic_store_bench.sv
module frame_elastic_store_bench;
  logic       clk = 1'b0;
  logic       wrst = 1'b1, rrst = 1'b1;
  logic       wr_en = 1'b0, wr_bit = 1'b0, wr_fsync = 1'b0;
  logic       rd_en = 1'b0, rd_t1 = 1'b0, rd_fbit = 1'b0;
  logic [1:0] slip_clr = 2'b00;
  logic       rd_bit;
  logic [1:0] slip_flags;

  always #2 clk = ~clk;

  frame_elastic_store u_frame_elastic_store (
    .wclk(clk), .wrst(wrst), .wr_en(wr_en), .wr_bit(wr_bit),
    .wr_fsync(wr_fsync), .rclk(clk), .rrst(rrst), .rd_en(rd_en),
    .rd_t1(rd_t1), .rd_fbit(rd_fbit), .rd_bit(rd_bit),
    .slip_clr(slip_clr), .slip_flags(slip_flags)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int reps, dels, frames, prev_n, cfail, fidx, flen;
  bit aligned, t1mode, rd_pend;
  bit fbuf [256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat(input int n, input int i);
    if (i < 8) return 0;
    if (i < 24) return (n >> (i - 8)) & 1;
    return (((n * 13 + i * 7 + (i >> 3)) % 5) < 2) ? 1 : 0;
  endfunction

  function automatic int stored_idx(input int p);
    int k, b;
    if (!t1mode) return p;
    if (p == 0) return -1;
    k = (p - 1) / 8;
    b = (p - 1) % 8;
    return (k + k / 3 + 1) * 8 + b;
  endfunction

  task automatic frame_done();
    int n, err, d, ix, e;
    n = 0;
    err = 0;
    for (int p = 0; p < flen; p++) begin
      ix = stored_idx(p);
      if (ix >= 8 && ix < 24 && fbuf[p]) n = n | (1 << (ix - 8));
    end
    for (int p = 0; p < flen; p++) begin
      ix = stored_idx(p);
      e = (ix < 0) ? 0 : pat(n, ix);
      if (int'(fbuf[p]) != e) err++;
    end
    if (err != 0) cfail++;
    chk(err == 0, t1mode ? "R10 frame content/timeslot map" : "R4 frame content", err, 0);
    if (frames == 0) begin
      chk(n == 0, "R3 first frame number", n, 0);
    end else begin
      d = (n - prev_n) & 16'hffff;
      if (d == 0) reps++;
      if (d == 2) dels++;
      chk(d <= 2, "R8 frame sequence step", d, 1);
    end
    prev_n = n;
    frames++;
  endtask

  task automatic take_bit(input bit b);
    if (!aligned) begin
      if (!b) begin
        aligned = 1'b1;
        fbuf[0] = 1'b0;
        fidx = 1;
      end
    end else begin
      fbuf[fidx] = b;
      fidx++;
      if (fidx == flen) begin
        frame_done();
        fidx = 0;
      end
    end
  endtask

  task automatic run(input bit t1, input int wn, input int wd, input int rn,
                     input int rdn, input bit burst, input int ncyc, input int xfs);
    int accw, accr, junk, n, i;
    rd_t1 = t1; t1mode = t1; flen = t1 ? 193 : 256;
    wrst = 1'b1; rrst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_fsync = 1'b0;
    slip_clr = 2'b00; rd_fbit = 1'b0;
    repeat (4) @(negedge clk);
    wrst = 1'b0; rrst = 1'b0;
    reps = 0; dels = 0; frames = 0; prev_n = 0; cfail = 0; fidx = 0;
    aligned = 1'b0; rd_pend = 1'b0;
    @(negedge clk);
    chk(rd_bit == 1'b1 && slip_flags == 2'b00, "R1 reset state",
        int'({rd_bit, slip_flags}), 4);
    accw = 0; accr = 0; junk = 0; n = 0; i = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (rd_pend) take_bit(rd_bit);
      accw += wn;
      if (accw >= wd) begin
        accw -= wd;
        wr_en = 1'b1;
        if (junk < 5) begin
          wr_bit = 1'b1; wr_fsync = 1'b0; junk++;
        end else begin
          wr_bit = 1'(pat(n, i));
          wr_fsync = (n == 0 && i == 0) || (n == xfs && i == 100);
          i++;
          if (i == 256) begin i = 0; n++; end
        end
      end else begin
        wr_en = 1'b0; wr_fsync = 1'b0;
      end
      if (burst) rd_en = (c % 8) < 4;
      else begin
        accr += rn;
        if (accr >= rdn) begin accr -= rdn; rd_en = 1'b1; end
        else rd_en = 1'b0;
      end
      rd_pend = rd_en;
    end
    @(negedge clk);
    if (rd_pend) take_bit(rd_bit);
    wr_en = 1'b0; rd_en = 1'b0; wr_fsync = 1'b0; rd_pend = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [1:0] m);
    slip_clr = m;
    @(negedge clk);
    slip_clr = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    // R2: junk before marker and a stray marker in frame 3; R5 equal rates
    run(1'b0, 1, 2, 1, 2, 1'b0, 20000, 3);
    chk(frames >= 30, "R5 frames delivered at equal rate", frames, 30);
    chk(cfail == 0, "R2 pre-marker and late marker ignored", cfail, 0);
    chk(reps == 0 && dels == 0, "R5 no slip at equal rate", reps + dels, 0);
    chk(slip_flags == 2'b00, "R5 flags clear", int'(slip_flags), 0);

    // R6: slow writer
    run(1'b0, 7, 16, 1, 2, 1'b0, 25000, -1);
    chk(reps >= 3, "R6 repeats observed", reps, 3);
    chk(dels == 0, "R6 no deletes", dels, 0);
    chk(slip_flags == 2'b01, "R6 repeat flag", int'(slip_flags), 1);
    clear_flags(2'b10);
    chk(slip_flags == 2'b01, "R9 delete clear leaves repeat", int'(slip_flags), 1);
    clear_flags(2'b01);
    chk(slip_flags == 2'b00, "R9 repeat cleared", int'(slip_flags), 0);

    // R7: fast writer
    run(1'b0, 9, 16, 1, 2, 1'b0, 25000, -1);
    chk(dels >= 3, "R7 deletes observed", dels, 3);
    chk(reps == 0, "R7 no repeats", reps, 0);
    chk(slip_flags == 2'b10, "R7 delete flag", int'(slip_flags), 2);
    clear_flags(2'b01);
    chk(slip_flags == 2'b10, "R9 repeat clear leaves delete", int'(slip_flags), 2);
    clear_flags(2'b10);
    chk(slip_flags == 2'b00, "R9 delete cleared", int'(slip_flags), 0);

    // R5: bursty reads at one per cycle
    run(1'b0, 1, 2, 0, 1, 1'b1, 15000, -1);
    chk(frames >= 20, "R5 burst frames delivered", frames, 20);
    chk(reps == 0 && dels == 0, "R5 no slip with bursts", reps + dels, 0);

    // R10: 193-bit output frames
    run(1'b1, 1, 2, 193, 512, 1'b0, 20000, -1);
    chk(frames >= 30, "R10 T1 frames delivered", frames, 30);
    chk(reps == 0 && dels == 0, "R10 no slip at matched frame rate", reps + dels, 0);
    chk(slip_flags == 2'b00, "R10 flags clear", int'(slip_flags), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule